// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Slice

This block compares two unsigned operands, X and Y, and raises exactly one of three flags: X greater than Y, X equal to Y, or X less than Y. The comparison is built from identical narrow slices. Each slice forms a greater, a less and an equal term for every bit position. The most significant position where the operands differ decides the slice's answer.

Each slice also takes three cascade inputs: greater-in, equal-in and less-in. These inputs matter only when every local bit of X matches the same bit of Y. In that case the slice passes them straight through. Otherwise it ignores them.

Wider comparators are made by chaining slices. The three flags of a lower slice drive the cascade inputs of the slice above it. The cascade inputs of the least significant slice come out as top-level ports. For a standalone comparison they are tied to greater-in 0, equal-in 1 and less-in 0.

The chain itself is combinational. The three flags are captured in one output register with a synchronous reset.

Top module: `magcmp_cascade`

## Requirements
- R1: When X is greater than Y (unsigned), the outputs one clock later are gt_out=1, eq_out=0, lt_out=0.
- R2: When X is less than Y (unsigned), the outputs one clock later are gt_out=0, eq_out=0, lt_out=1.
- R3: The most significant differing bit decides the result, whatever the lower bits hold. For example, with 8-bit operands, X=8'h80 and Y=8'h7F give gt_out=1.
- R4: When X equals Y, the outputs one clock later copy the cascade inputs exactly: gt_out=casc_gt_in, eq_out=casc_eq_in and lt_out=casc_lt_in. This holds for all eight input combinations, including those with several inputs set or none set.
- R5: When X differs from Y, the cascade inputs have no effect on the outputs.
- R6: When exactly one cascade input is high, exactly one of the three outputs is high.
- R7: The outputs are registered. A change on the inputs reaches the outputs at the first rising clock edge after it and not before.
- R8: While rst is high at a rising edge, the outputs become gt_out=0, eq_out=1, lt_out=0.
- R9: The operand width is SLICE_W*SLICES. Slice k compares bits [k*SLICE_W +: SLICE_W], and its flags feed the cascade inputs of slice k+1. Bit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | SLICE_W*SLICES | Operand X, unsigned |
| y_in | input | SLICE_W*SLICES | Operand Y, unsigned |
| casc_gt_in | input | 1 | Greater-in for the least significant slice |
| casc_eq_in | input | 1 | Equal-in for the least significant slice |
| casc_lt_in | input | 1 | Less-in for the least significant slice |
| gt_out | output | 1 | Registered X greater than Y flag |
| eq_out | output | 1 | Registered X equal to Y flag |
| lt_out | output | 1 | Registered X less than Y flag |

## Verification
The bench builds the block with its default values: two slices of four bits each, giving an 8-bit comparison. At this width every pair of operands can be swept, all 65,536 of them, through a real slice-to-slice cascade link. That sweep reaches every case where the upper slice decides alone and every case where it defers to the lower one.

On top of the sweep, the bench drives operand pairs that match in all eight bits together with each of the eight cascade combinations. It also drives differing pairs with cascade values chosen to mislead. It checks the one-clock latency and the reset value, including a reset applied in the middle of the run.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  localparam rel_t REL_TIE = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/magcmp_bit_terms.sv
module magcmp_bit_terms #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] l,
  output logic [W-1:0] e
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i] = a[i] & ~b[i];
    assign l[i] = ~a[i] & b[i];
    assign e[i] = ~(g[i] | l[i]);
  end

endmodule

// File: rtl/magcmp_slice.sv
module magcmp_slice
  import magcmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  rel_t         casc_in,
  output rel_t         rel_out
);

  logic [W-1:0] g_bits;
  logic [W-1:0] l_bits;
  logic [W-1:0] e_bits;
  logic         gt_loc;
  logic         lt_loc;
  logic         all_eq;

  magcmp_bit_terms #(.W(W)) u_terms (
    .a(a),
    .b(b),
    .g(g_bits),
    .l(l_bits),
    .e(e_bits)
  );

  // Walk from the top bit down; a term counts only while every bit above matched.
  always_comb begin
    logic above_eq;
    above_eq = 1'b1;
    gt_loc   = 1'b0;
    lt_loc   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      gt_loc   = gt_loc | (above_eq & g_bits[i]);
      lt_loc   = lt_loc | (above_eq & l_bits[i]);
      above_eq = above_eq & e_bits[i];
    end
    all_eq = above_eq;
  end

  assign rel_out.gt = gt_loc | (all_eq & casc_in.gt);
  assign rel_out.eq = all_eq & casc_in.eq;
  assign rel_out.lt = lt_loc | (all_eq & casc_in.lt);

endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
  import magcmp_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2
) (
  input  logic [SLICE_W*SLICES-1:0] x,
  input  logic [SLICE_W*SLICES-1:0] y,
  input  rel_t                      casc_in,
  output rel_t                      rel_out
);

  rel_t link [SLICES+1];

  assign link[0] = casc_in;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    magcmp_slice #(.W(SLICE_W)) u_slice (
      .a      (x[k*SLICE_W +: SLICE_W]),
      .b      (y[k*SLICE_W +: SLICE_W]),
      .casc_in(link[k]),
      .rel_out(link[k+1])
    );
  end

  assign rel_out = link[SLICES];

endmodule

// File: rtl/magcmp_cascade.sv
module magcmp_cascade
  import magcmp_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2,
  localparam int TOTAL_W = SLICE_W * SLICES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TOTAL_W-1:0] x_in,
  input  logic [TOTAL_W-1:0] y_in,
  input  logic               casc_gt_in,
  input  logic               casc_eq_in,
  input  logic               casc_lt_in,
  output logic               gt_out,
  output logic               eq_out,
  output logic               lt_out
);

  rel_t casc_w;
  rel_t rel_w;
  rel_t rel_q;

  assign casc_w = '{gt: casc_gt_in, eq: casc_eq_in, lt: casc_lt_in};

  magcmp_chain #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chain (
    .x      (x_in),
    .y      (y_in),
    .casc_in(casc_w),
    .rel_out(rel_w)
  );

  always_ff @(posedge clk) begin
    if (rst) rel_q <= REL_TIE;
    else     rel_q <= rel_w;
  end

  assign gt_out = rel_q.gt;
  assign eq_out = rel_q.eq;
  assign lt_out = rel_q.lt;

  // R1
  greater_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (x_in > y_in) |=> (gt_out && !eq_out && !lt_out));

  // R2
  less_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (x_in < y_in) |=> (!gt_out && !eq_out && lt_out));

  // R4
  match_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (x_in == y_in) |=> (gt_out == $past(casc_gt_in) &&
                        eq_out == $past(casc_eq_in) &&
                        lt_out == $past(casc_lt_in)));

  // R6
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({casc_gt_in, casc_eq_in, casc_lt_in}) |=> $onehot({gt_out, eq_out, lt_out}));

endmodule

// File: tb/magcmp_cascade_test.sv
module magcmp_cascade_test;

  localparam int SLICE_W = 4;
  localparam int SLICES  = 2;
  localparam int TW      = SLICE_W * SLICES;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] x_in = '0;
  logic [TW-1:0] y_in = '0;
  logic          cg = 1'b0;
  logic          ce = 1'b1;
  logic          cl = 1'b0;
  logic          gt_out, eq_out, lt_out;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];

  always #2.5 clk = ~clk;

  magcmp_cascade #(.SLICE_W(SLICE_W), .SLICES(SLICES)) uut (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in),
    .casc_gt_in(cg), .casc_eq_in(ce), .casc_lt_in(cl),
    .gt_out(gt_out), .eq_out(eq_out), .lt_out(lt_out)
  );

  function automatic logic [2:0] model(int x, int y, logic g, logic e, logic l);
    if (x > y) return 3'b100;
    if (x < y) return 3'b001;
    return {g, e, l};
  endfunction

  task automatic check(logic [2:0] exp, string req);
    checks++;
    if ({gt_out, eq_out, lt_out} !== exp) begin
      errors++;
      $display("FAIL %s x=%0d y=%0d actual=%b expected=%b", req, x_in, y_in,
               {gt_out, eq_out, lt_out}, exp);
    end
  endtask

  // Drive at the falling edge, compare just after the next rising edge.
  task automatic apply(int x, int y, logic g, logic e, logic l, string req);
    @(negedge clk);
    x_in = x[TW-1:0]; y_in = y[TW-1:0]; cg = g; ce = e; cl = l;
    exp_q.push_back(model(x, y, g, e, l));
    @(posedge clk); #1;
    check(exp_q.pop_front(), req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset value with operands that would otherwise say greater
    x_in = 8'hF0; y_in = 8'h01;
    repeat (3) @(posedge clk);
    #1 check(3'b010, "R8 reset");
    @(negedge clk) rst = 1'b0;

    // R1 R2 R3 basic and priority patterns
    apply(8'h80, 8'h7F, 0, 1, 0, "R3 msb decides");
    apply(8'h7F, 8'h80, 0, 1, 0, "R3 msb decides lt");
    apply(8'h10, 8'h0F, 0, 1, 0, "R9 upper slice decides");
    apply(8'h05, 8'h04, 0, 1, 0, "R1 lower slice via cascade");
    apply(8'h34, 8'h35, 0, 1, 0, "R2 lower slice via cascade");
    apply(8'hFF, 8'h00, 0, 1, 0, "R1 extremes");

    // R4: full match passes every cascade combination
    for (int c = 0; c < 8; c++) begin
      apply(8'hA5, 8'hA5, c[2], c[1], c[0], "R4 match pass-through");
      apply(8'h00, 8'h00, c[2], c[1], c[0], "R4 zero match");
    end

    // R5: cascade ignored on a mismatch
    for (int c = 0; c < 8; c++) begin
      apply(8'h21, 8'h20, c[2], c[1], c[0], "R5 ignore cascade gt");
      apply(8'h20, 8'h21, c[2], c[1], c[0], "R5 ignore cascade lt");
    end

    // R7: no change before the edge, change after it
    apply(8'h01, 8'h02, 0, 1, 0, "R7 setup");
    @(negedge clk);
    x_in = 8'h09; y_in = 8'h02;
    #1 check(3'b001, "R7 before edge");
    @(posedge clk); #1 check(3'b100, "R7 after edge");

    // R6 R9: exhaustive sweep with standalone tie-off
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        apply(x, y, 0, 1, 0, "R6 R9 sweep");
        if ($countones({gt_out, eq_out, lt_out}) != 1) begin
          checks++; errors++;
          $display("FAIL R6 flags=%b expected one high", {gt_out, eq_out, lt_out});
        end
      end
    end

    // R8: mid-run reset
    @(negedge clk);
    rst = 1'b1; x_in = 8'h00; y_in = 8'hFF;
    @(posedge clk); #1 check(3'b010, "R8 mid-run reset");
    @(negedge clk) rst = 1'b0;
    apply(8'h00, 8'hFF, 0, 1, 0, "R2 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule